// File: doc/BRIEF.md
# NAND Page Register Column Pointer

This block sits on the device side of a NAND page register that holds a main region and a small spare region. It watches a decoded bus on which command, address and data strobes have already been separated. From the opcodes it keeps a pointer that picks one of three regions of the page register: the lower half of the main region, the upper half of the main region, or the spare bytes. The first address cycle after a command turns that pointer into a starting column. Each data strobe then moves the column forward by one.

Read strobes roll over at the end of the page into the same region of the next page, so that sequential reads can go on without a new command. Write strobes stop at the last column and flag any extra bytes. After a program confirm, the pointer returns to the lower half unless it was set to the spare region. The block also flags opcodes it does not know and spare-region requests made while the spare region is locked.

Top module: `nand_ptr_unit`

## Requirements
- R1: After reset, `col` is 0, `area` is 0 (lower half), and `end_of_page`, `page_next`, `overrun` and `illegal_cmd` are all low.
- R2: The `area` output shows the stored pointer. Opcode 0x00 sets it to 0 (lower half). Opcode 0x01 sets it to 1 (upper half). Opcode 0x50 sets it to 2 (spare). No other command moves `col` except 0xFF.
- R3: Only the first address cycle after a command loads `col`. With area 0 it loads `bus_d[7:0]`. With area 1 it loads 256 + `bus_d[7:0]`. With area 2 it loads 512 + `bus_d[3:0]`, and `bus_d[7:4]` is ignored. After opcode 0x60 (erase setup), no address cycle loads `col`.
- R4: Area 1 is used once. When an address cycle loads `col` from area 1, the stored pointer returns to area 0 on the next cycle.
- R5: Program confirm (0x10) sets area 2 if the pointer was 2, and area 0 otherwise. The opcodes 0x60, 0xD0, 0x70, 0x80 and 0x90 leave the pointer unchanged.
- R6: Opcode 0xFF sets area 0 and `col` 0.
- R7: While `spare_lock` is high, opcode 0x50 is rejected. `illegal_cmd` rises and the pointer is unchanged.
- R8: A read strobe adds one to `col`. The last column is 527 when `spare_lock` is low and 511 when it is high. `end_of_page` is high exactly when `col` equals the last column.
- R9: A read strobe at the last column moves `col` to the start of the same region on the next page. That start is 512 if the current access was loaded from area 2, and 0 otherwise. `page_next` pulses high for one cycle when this happens.
- R10: A write strobe adds one to `col` but stops at the last column. The first write at the last column is accepted. Each write after that sets `overrun`, which stays high until the next command.
- R11: Any opcode outside {00,01,50,80,10,60,D0,70,90,FF} sets `illegal_cmd` and leaves the pointer and `col` unchanged. `illegal_cmd` stays high until the next legal command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | Command strobe; `bus_d` holds an opcode |
| addr_vld | input | 1 | Address-cycle strobe |
| rd_stb | input | 1 | Data-out strobe |
| wr_stb | input | 1 | Data-in strobe |
| bus_d | input | DATA_W | Opcode or address byte |
| spare_lock | input | 1 | High makes the spare region inaccessible |
| col | output | clog2(MAIN_BYTES+SPARE_BYTES) | Current column |
| area | output | 2 | Stored pointer: 0 lower half, 1 upper half, 2 spare |
| end_of_page | output | 1 | Column is the last accessible column |
| page_next | output | 1 | One-cycle pulse when a read rolls over to the next page |
| overrun | output | 1 | A write arrived after the last column was filled |
| illegal_cmd | output | 1 | The last command was rejected |

## Verification
On every cycle, the assertions check the transition rules. A load from the upper half always sends the pointer back to the lower half. A rejected opcode never moves the pointer. A read at the last column always rolls over to a region start and pulses `page_next`. A write at the last column holds the column. `overrun` rises only on a write, and the reset opcode clears both the pointer and the column. Only the bench's scenarios can show that the loaded column values are correct in each region, including the ignored upper nibble in the spare region. The same holds for the different last column under `spare_lock`, the pointer that programming leaves behind, and the ordering of command, address and data sequences.

// File: rtl/nptr_pkg.sv
package nptr_pkg;
   typedef enum logic [1:0] {
      AREA_LO    = 2'd0,
      AREA_HI    = 2'd1,
      AREA_SPARE = 2'd2
   } area_e;

   localparam logic [7:0] OP_SEL_LO   = 8'h00;
   localparam logic [7:0] OP_SEL_HI   = 8'h01;
   localparam logic [7:0] OP_SEL_SP   = 8'h50;
   localparam logic [7:0] OP_LOAD     = 8'h80;
   localparam logic [7:0] OP_PROG     = 8'h10;
   localparam logic [7:0] OP_ERS_SET  = 8'h60;
   localparam logic [7:0] OP_ERS_GO   = 8'hD0;
   localparam logic [7:0] OP_STATUS   = 8'h70;
   localparam logic [7:0] OP_IDENT    = 8'h90;
   localparam logic [7:0] OP_RESET    = 8'hFF;

   typedef struct packed {
      logic sel_lo;
      logic sel_hi;
      logic sel_sp;
      logic prog_go;
      logic ers_setup;
      logic rst_cmd;
      logic legal;
   } cmd_dec_t;
endpackage

// File: rtl/nptr_cmd_dec.sv
module nptr_cmd_dec
   import nptr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] opcode,
   input  logic              spare_lock,
   output cmd_dec_t          dec
);
   function automatic logic is_op(input logic [DATA_W-1:0] v, input logic [7:0] op);
      return v == DATA_W'(op);
   endfunction

   logic known;

   always_comb begin
      known = is_op(opcode, OP_SEL_LO) || is_op(opcode, OP_SEL_HI) ||
              is_op(opcode, OP_SEL_SP) || is_op(opcode, OP_LOAD)   ||
              is_op(opcode, OP_PROG)   || is_op(opcode, OP_ERS_SET) ||
              is_op(opcode, OP_ERS_GO) || is_op(opcode, OP_STATUS) ||
              is_op(opcode, OP_IDENT)  || is_op(opcode, OP_RESET);
      dec.sel_lo    = is_op(opcode, OP_SEL_LO);
      dec.sel_hi    = is_op(opcode, OP_SEL_HI);
      dec.sel_sp    = is_op(opcode, OP_SEL_SP) && !spare_lock;
      dec.prog_go   = is_op(opcode, OP_PROG);
      dec.ers_setup = is_op(opcode, OP_ERS_SET);
      dec.rst_cmd   = is_op(opcode, OP_RESET);
      dec.legal     = known && !(is_op(opcode, OP_SEL_SP) && spare_lock);
   end
endmodule

// File: rtl/nptr_area_reg.sv
module nptr_area_reg
   import nptr_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  cmd_stb,
   input  logic  sel_lo,
   input  logic  sel_hi,
   input  logic  sel_sp,
   input  logic  prog_go,
   input  logic  rst_cmd,
   input  logic  legal,
   input  logic  col_load,
   output area_e area_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         area_q <= AREA_LO;
      end else if (cmd_stb) begin
         if (rst_cmd || sel_lo)  area_q <= AREA_LO;
         else if (sel_hi)        area_q <= AREA_HI;
         else if (sel_sp)        area_q <= AREA_SPARE;
         else if (prog_go)       area_q <= (area_q == AREA_SPARE) ? AREA_SPARE : AREA_LO;
      end else if (col_load && area_q == AREA_HI) begin
         area_q <= AREA_LO;
      end
   end

   // R4
   hi_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col_load && !cmd_stb && area_q == AREA_HI) |=> (area_q == AREA_LO));

   // R11
   bad_op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb && !legal) |=> (area_q == $past(area_q)));
endmodule

// File: rtl/nptr_col_ctr.sv
module nptr_col_ctr
   import nptr_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int MAIN_BYTES  = 512,
   parameter int SPARE_BYTES = 16,
   localparam int COL_W      = $clog2(MAIN_BYTES + SPARE_BYTES),
   localparam int HALF_W     = $clog2(MAIN_BYTES / 2),
   localparam int SPARE_W    = $clog2(SPARE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_stb,
   input  logic              col_zero,
   input  logic              load,
   input  area_e             load_area,
   input  logic [DATA_W-1:0] load_d,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic              spare_lock,
   output logic [COL_W-1:0]  col,
   output logic              eop,
   output logic              page_next,
   output logic              overrun
);
   localparam logic [COL_W-1:0] HALF_BASE  = COL_W'(MAIN_BYTES / 2);
   localparam logic [COL_W-1:0] SPARE_BASE = COL_W'(MAIN_BYTES);
   localparam logic [COL_W-1:0] LAST_MAIN  = COL_W'(MAIN_BYTES - 1);
   localparam logic [COL_W-1:0] LAST_FULL  = COL_W'(MAIN_BYTES + SPARE_BYTES - 1);

   logic [COL_W-1:0] wrap_base;
   logic [COL_W-1:0] load_val;
   logic [COL_W-1:0] last_col;
   logic             full_q;

   always_comb begin
      unique case (load_area)
         AREA_HI:    load_val = HALF_BASE + COL_W'(load_d[HALF_W-1:0]);
         AREA_SPARE: load_val = SPARE_BASE + COL_W'(load_d[SPARE_W-1:0]);
         default:    load_val = COL_W'(load_d[HALF_W-1:0]);
      endcase
      last_col = spare_lock ? LAST_MAIN : LAST_FULL;
      eop      = (col == last_col);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col       <= '0;
         wrap_base <= '0;
         full_q    <= 1'b0;
         overrun   <= 1'b0;
         page_next <= 1'b0;
      end else begin
         page_next <= 1'b0;
         if (cmd_stb) begin
            overrun <= 1'b0;
            full_q  <= 1'b0;
            if (col_zero) begin
               col       <= '0;
               wrap_base <= '0;
            end
         end else if (load) begin
            col       <= load_val;
            wrap_base <= (load_area == AREA_SPARE) ? SPARE_BASE : '0;
            full_q    <= 1'b0;
         end else if (rd_stb) begin
            if (eop) begin
               col       <= wrap_base;
               page_next <= 1'b1;
            end else begin
               col <= col + 1'b1;
            end
         end else if (wr_stb) begin
            if (full_q)   overrun <= 1'b1;
            else if (eop) full_q  <= 1'b1;
            else          col     <= col + 1'b1;
         end
      end
   end

   // R9
   read_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !cmd_stb && !load && eop) |=>
         (page_next && (col == '0 || col == SPARE_BASE)));

   // R10
   write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !rd_stb && !cmd_stb && !load && eop) |=> (col == $past(col)));

   // R10
   ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(wr_stb));
endmodule

// File: rtl/nand_ptr_unit.sv
module nand_ptr_unit
   import nptr_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int MAIN_BYTES  = 512,
   parameter int SPARE_BYTES = 16
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       cmd_vld,
   input  logic                                       addr_vld,
   input  logic                                       rd_stb,
   input  logic                                       wr_stb,
   input  logic [DATA_W-1:0]                          bus_d,
   input  logic                                       spare_lock,
   output logic [$clog2(MAIN_BYTES+SPARE_BYTES)-1:0]  col,
   output logic [1:0]                                 area,
   output logic                                       end_of_page,
   output logic                                       page_next,
   output logic                                       overrun,
   output logic                                       illegal_cmd
);
   localparam int HALF_W  = $clog2(MAIN_BYTES / 2);
   localparam int SPARE_W = $clog2(SPARE_BYTES);

   generate
      if (MAIN_BYTES < 4 || (MAIN_BYTES & (MAIN_BYTES - 1)) != 0) begin : g_bad_main
         $error("MAIN_BYTES must be a power of two, at least 4");
      end
      if (SPARE_BYTES < 2 || (SPARE_BYTES & (SPARE_BYTES - 1)) != 0 ||
          SPARE_BYTES > MAIN_BYTES / 2) begin : g_bad_spare
         $error("SPARE_BYTES must be a power of two between 2 and MAIN_BYTES/2");
      end
      if (DATA_W < 8 || DATA_W < HALF_W || DATA_W < SPARE_W) begin : g_bad_width
         $error("DATA_W too narrow for opcodes or column offsets");
      end
   endgenerate

   cmd_dec_t dec;
   area_e    area_q;
   logic     addr_s, rd_s, wr_s, first_addr, col_load;

   assign addr_s   = addr_vld && !cmd_vld;
   assign rd_s     = rd_stb && !cmd_vld && !addr_vld;
   assign wr_s     = wr_stb && !cmd_vld && !addr_vld && !rd_stb;
   assign col_load = addr_s && first_addr;
   assign area     = area_q;

   nptr_cmd_dec #(.DATA_W(DATA_W)) u_dec (
      .opcode     (bus_d),
      .spare_lock (spare_lock),
      .dec        (dec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_addr  <= 1'b0;
         illegal_cmd <= 1'b0;
      end else if (cmd_vld) begin
         first_addr  <= !dec.ers_setup;
         illegal_cmd <= !dec.legal;
      end else if (addr_s) begin
         first_addr  <= 1'b0;
      end
   end

   nptr_area_reg u_area (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_stb  (cmd_vld),
      .sel_lo   (dec.sel_lo),
      .sel_hi   (dec.sel_hi),
      .sel_sp   (dec.sel_sp),
      .prog_go  (dec.prog_go),
      .rst_cmd  (dec.rst_cmd),
      .legal    (dec.legal),
      .col_load (col_load),
      .area_q   (area_q)
   );

   nptr_col_ctr #(
      .DATA_W      (DATA_W),
      .MAIN_BYTES  (MAIN_BYTES),
      .SPARE_BYTES (SPARE_BYTES)
   ) u_col (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_stb    (cmd_vld),
      .col_zero   (dec.rst_cmd),
      .load       (col_load),
      .load_area  (area_q),
      .load_d     (bus_d),
      .rd_stb     (rd_s),
      .wr_stb     (wr_s),
      .spare_lock (spare_lock),
      .col        (col),
      .eop        (end_of_page),
      .page_next  (page_next),
      .overrun    (overrun)
   );

   // R6
   reset_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && dec.rst_cmd) |=> (col == '0 && area == 2'd0));

   // R7
   spare_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && spare_lock && !dec.legal) |=> (illegal_cmd && $stable(area)));
endmodule

// File: tb/tb_nand_ptr_unit.sv
module tb_nand_ptr_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_vld = 1'b0, addr_vld = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
   logic [7:0] bus_d = 8'h00;
   logic       spare_lock = 1'b0;
   logic [9:0] col;
   logic [1:0] area;
   logic       end_of_page, page_next, overrun, illegal_cmd;
   int         checks = 0, failures = 0;

   always #10 clk = ~clk;

   nand_ptr_unit dut (
      .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .addr_vld(addr_vld),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .bus_d(bus_d), .spare_lock(spare_lock),
      .col(col), .area(area), .end_of_page(end_of_page), .page_next(page_next),
      .overrun(overrun), .illegal_cmd(illegal_cmd)
   );

   // {req[3:0], kind[1:0] (0 cmd,1 addr,2 read,3 write), data, col, area, eop, ill, ovr}
   localparam int NV = 29;
   localparam logic [28:0] VEC [NV] = '{
      {4'd2,  2'd0, 8'h00, 10'd0,   2'd0, 1'b0, 1'b0, 1'b0}, // R2
      {4'd3,  2'd1, 8'h05, 10'd5,   2'd0, 1'b0, 1'b0, 1'b0}, // R3
      {4'd3,  2'd1, 8'h12, 10'd5,   2'd0, 1'b0, 1'b0, 1'b0}, // R3 row cycle
      {4'd3,  2'd1, 8'h03, 10'd5,   2'd0, 1'b0, 1'b0, 1'b0}, // R3
      {4'd8,  2'd2, 8'h00, 10'd6,   2'd0, 1'b0, 1'b0, 1'b0}, // R8
      {4'd2,  2'd0, 8'h01, 10'd6,   2'd1, 1'b0, 1'b0, 1'b0}, // R2
      {4'd4,  2'd1, 8'h0A, 10'd266, 2'd0, 1'b0, 1'b0, 1'b0}, // R4
      {4'd8,  2'd2, 8'h00, 10'd267, 2'd0, 1'b0, 1'b0, 1'b0}, // R8
      {4'd2,  2'd0, 8'h50, 10'd267, 2'd2, 1'b0, 1'b0, 1'b0}, // R2
      {4'd3,  2'd1, 8'hF3, 10'd515, 2'd2, 1'b0, 1'b0, 1'b0}, // R3 nibble
      {4'd8,  2'd2, 8'h00, 10'd516, 2'd2, 1'b0, 1'b0, 1'b0}, // R8
      {4'd5,  2'd0, 8'h60, 10'd516, 2'd2, 1'b0, 1'b0, 1'b0}, // R5
      {4'd3,  2'd1, 8'h07, 10'd516, 2'd2, 1'b0, 1'b0, 1'b0}, // R3 erase
      {4'd5,  2'd0, 8'hD0, 10'd516, 2'd2, 1'b0, 1'b0, 1'b0}, // R5
      {4'd5,  2'd0, 8'h80, 10'd516, 2'd2, 1'b0, 1'b0, 1'b0}, // R5
      {4'd3,  2'd1, 8'h0E, 10'd526, 2'd2, 1'b0, 1'b0, 1'b0}, // R3
      {4'd10, 2'd3, 8'hAA, 10'd527, 2'd2, 1'b1, 1'b0, 1'b0}, // R10
      {4'd10, 2'd3, 8'h55, 10'd527, 2'd2, 1'b1, 1'b0, 1'b0}, // R10
      {4'd10, 2'd3, 8'h66, 10'd527, 2'd2, 1'b1, 1'b0, 1'b1}, // R10
      {4'd5,  2'd0, 8'h10, 10'd527, 2'd2, 1'b1, 1'b0, 1'b0}, // R5
      {4'd2,  2'd0, 8'h01, 10'd527, 2'd1, 1'b1, 1'b0, 1'b0}, // R2
      {4'd5,  2'd0, 8'h80, 10'd527, 2'd1, 1'b1, 1'b0, 1'b0}, // R5
      {4'd4,  2'd1, 8'h00, 10'd256, 2'd0, 1'b0, 1'b0, 1'b0}, // R4
      {4'd5,  2'd0, 8'h10, 10'd256, 2'd0, 1'b0, 1'b0, 1'b0}, // R5
      {4'd2,  2'd0, 8'h50, 10'd256, 2'd2, 1'b0, 1'b0, 1'b0}, // R2
      {4'd5,  2'd0, 8'h10, 10'd256, 2'd2, 1'b0, 1'b0, 1'b0}, // R5
      {4'd11, 2'd0, 8'h3C, 10'd256, 2'd2, 1'b0, 1'b1, 1'b0}, // R11
      {4'd11, 2'd0, 8'h70, 10'd256, 2'd2, 1'b0, 1'b0, 1'b0}, // R11
      {4'd6,  2'd0, 8'hFF, 10'd0,   2'd0, 1'b0, 1'b0, 1'b0}  // R6
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] k, input logic [7:0] d);
      @(negedge clk);
      cmd_vld = (k == 2'd0); addr_vld = (k == 2'd1);
      rd_stb = (k == 2'd2); wr_stb = (k == 2'd3); bus_d = d;
      @(negedge clk);
      cmd_vld = 1'b0; addr_vld = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0;
   endtask

   initial begin
      #4_000_000;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 col", int'(col), 0);
      chk("R1 area", int'(area), 0);
      chk("R1 flags", int'({end_of_page, page_next, overrun, illegal_cmd}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VEC[i][28:25], i);
         drive(VEC[i][24:23], VEC[i][22:15]);
         chk({tag, " col"},  int'(col),         int'(VEC[i][14:5]));
         chk({tag, " area"}, int'(area),        int'(VEC[i][4:3]));
         chk({tag, " eop"},  int'(end_of_page), int'(VEC[i][2]));
         chk({tag, " ill"},  int'(illegal_cmd), int'(VEC[i][1]));
         chk({tag, " ovr"},  int'(overrun),     int'(VEC[i][0]));
      end

      // R9 spare-region read roll-over
      drive(2'd0, 8'h50);
      drive(2'd1, 8'h0F);
      chk("R3 spare last col", int'(col), 527);
      chk("R8 eop at 527", int'(end_of_page), 1);
      drive(2'd2, 8'h00);
      chk("R9 spare wrap col", int'(col), 512);
      chk("R9 page_next pulse", int'(page_next), 1);
      @(negedge clk);
      chk("R9 page_next one cycle", int'(page_next), 0);

      // R7 spare locked
      spare_lock = 1'b1;
      drive(2'd0, 8'h50);
      chk("R7 illegal", int'(illegal_cmd), 1);
      chk("R7 area kept", int'(area), 2);
      drive(2'd0, 8'h01);
      drive(2'd1, 8'hFF);
      chk("R8 locked last col", int'(col), 511);
      chk("R8 locked eop", int'(end_of_page), 1);
      drive(2'd2, 8'h00);
      chk("R9 main wrap col", int'(col), 0);
      chk("R9 main page_next", int'(page_next), 1);

      // R8 unlocked: 511 is not last
      spare_lock = 1'b0;
      drive(2'd0, 8'h01);
      drive(2'd1, 8'hFF);
      chk("R8 unlocked eop at 511", int'(end_of_page), 0);
      drive(2'd2, 8'h00);
      chk("R8 read into spare", int'(col), 512);
      chk("R8 no page_next", int'(page_next), 0);

      // R1 reset in the middle of a run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk("R1 mid col", int'(col), 0);
      chk("R1 mid area", int'(area), 0);
      rst_n = 1'b1;

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule